// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execute stage of a small 32-bit core. In a single combinational path it performs add, subtract, reverse subtract, OR, AND, XOR and NOT. The two operands come either from two register values or from one register value and an immediate. The immediate is widened in the way the operation class requires. The block drives the 32-bit result together with the next value of a four-bit status word. That status word holds zero, sign, carry and overflow flags.

Each operation writes its own subset of the flags, and the others keep their value. The status word lives in a register inside the block. That register takes the new value only on a clock edge where the update strobe is high. Operand fetch, result write-back and instruction decode stay outside the block. The caller gives the operation as a 4-bit code.

Top module: `flag_alu`

## Requirements
- R1: While `rst_ni` is low and after its release, before any update, `flags_o` is 0.
- R2: Add codes: 0 gives `opb_i + opa_i`. Code 1 gives `opb_i` plus `imm_i[4:0]` sign-extended to 32 bits. Code 2 gives `opb_i` plus `imm_i[15:0]` sign-extended. All three wrap modulo 2^32.
- R3: For codes 0 to 2 the next flags are as follows. Z (bit 0) is set for a zero result. S (bit 1) equals result bit 31. OV (bit 2) is set when the two addends share a sign and the result's sign differs from it. CY (bit 3) is the unsigned carry out of bit 31.
- R4: Code 3 gives `opb_i - opa_i`. CY is set when `opb_i < opa_i` as unsigned values. OV is set when the operand signs differ and the result's sign differs from `opb_i`'s sign. Z and S follow R3.
- R5: Code 4 gives `opa_i - opb_i`. CY is set when `opa_i < opb_i` unsigned. OV is set when the operand signs differ and the result's sign differs from `opa_i`'s sign. Z and S follow R3.
- R6: The following codes set Z and S from the result, clear OV and keep CY. Code 5 gives `opb_i | opa_i` and code 6 gives `opb_i | zext(imm_i)`. Code 7 gives `opb_i & opa_i`. Code 9 gives `opb_i ^ opa_i` and code 10 gives `opb_i ^ zext(imm_i)`. Code 11 gives `~opa_i`.
- R7: Code 8 gives `opb_i & zext(imm_i)`. It sets Z from the result, clears S and OV, and keeps CY.
- R8: On a rising clock edge with `upd_i` high, `flags_o` takes the value `flags_next_o` had before that edge. With `upd_i` low, `flags_o` keeps its value.
- R9: Codes 12 to 15 are reserved. They drive `res_o` to 0 and make `flags_next_o` equal `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| upd_i | input | 1 | Commit the next flags on this edge |
| res_o | output | 32 | Result |
| flags_next_o | output | 4 | Flags this operation would produce |
| flags_o | output | 4 | Committed flags |

## Verification
Every code runs against all pairs drawn from 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs separate signed overflow from unsigned carry, which a sum alone cannot do. They also expose a swapped subtraction order, because only the reverse subtract flips the borrow for such operands. The immediates cover the sign edges of the 5-bit and 16-bit fields, so sign extension and zero extension give different results. A long random run then mixes the codes with a random update strobe. This shows whether logic operations keep a carry left by an earlier add, and whether a low strobe truly holds the flags.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDI5  = 4'd1,
    OP_ADDI16 = 4'd2,
    OP_SUB    = 4'd3,
    OP_RSUB   = 4'd4,
    OP_OR     = 4'd5,
    OP_ORI    = 4'd6,
    OP_AND    = 4'd7,
    OP_ANDI   = 4'd8,
    OP_XOR    = 4'd9,
    OP_XORI   = 4'd10,
    OP_NOT    = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {LF_OR, LF_AND, LF_XOR, LF_NOT} logic_fn_e;
  typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_ANDI, CLS_NONE} op_cls_e;

  localparam int NFLG   = 4;
  localparam int FLG_Z  = 0;
  localparam int FLG_S  = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_CY = 3;
endpackage

// File: rtl/alu_opsel.sv
module alu_opsel import flag_alu_pkg::*; #(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     ar_x_o,
  output logic [W-1:0]     ar_y_o,
  output logic             ar_sub_o,
  output logic [W-1:0]     lg_a_o,
  output logic_fn_e        lg_fn_o,
  output op_cls_e          cls_o
);
  localparam int SEXT_S = W - SIMM_W;
  localparam int SEXT_L = W - IMM_W;

  logic [W-1:0] simm_s, simm_l, zimm;
  assign simm_s = {{SEXT_S{imm_i[SIMM_W-1]}}, imm_i[SIMM_W-1:0]};
  assign simm_l = {{SEXT_L{imm_i[IMM_W-1]}}, imm_i};
  assign zimm   = {{SEXT_L{1'b0}}, imm_i};

  always_comb begin
    ar_x_o   = opb_i;
    ar_y_o   = opa_i;
    ar_sub_o = 1'b0;
    lg_a_o   = opa_i;
    lg_fn_o  = LF_OR;
    cls_o    = CLS_NONE;
    case (op_i)
      OP_ADD:    cls_o = CLS_ARITH;
      OP_ADDI5:  begin cls_o = CLS_ARITH; ar_y_o = simm_s; end
      OP_ADDI16: begin cls_o = CLS_ARITH; ar_y_o = simm_l; end
      OP_SUB:    begin cls_o = CLS_ARITH; ar_sub_o = 1'b1; end
      OP_RSUB: begin
        cls_o    = CLS_ARITH;
        ar_sub_o = 1'b1;
        ar_x_o   = opa_i;
        ar_y_o   = opb_i;
      end
      OP_OR:   cls_o = CLS_LOGIC;
      OP_ORI:  begin cls_o = CLS_LOGIC; lg_a_o = zimm; end
      OP_AND:  begin cls_o = CLS_LOGIC; lg_fn_o = LF_AND; end
      OP_ANDI: begin cls_o = CLS_ANDI;  lg_fn_o = LF_AND; lg_a_o = zimm; end
      OP_XOR:  begin cls_o = CLS_LOGIC; lg_fn_o = LF_XOR; end
      OP_XORI: begin cls_o = CLS_LOGIC; lg_fn_o = LF_XOR; lg_a_o = zimm; end
      OP_NOT:  begin cls_o = CLS_LOGIC; lg_fn_o = LF_NOT; end
      default: cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         ov_o
);
  logic [W:0] wide;
  // for subtraction the bit above the top is the unsigned borrow
  assign wide  = sub_i ? ({1'b0, x_i} - {1'b0, y_i}) : ({1'b0, x_i} + {1'b0, y_i});
  assign sum_o = wide[W-1:0];
  assign cy_o  = wide[W];
  assign ov_o  = ((x_i[W-1] ^ y_i[W-1]) == sub_i) && (sum_o[W-1] != x_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic import flag_alu_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (fn_i)
      LF_OR:   res_o = b_i | a_i;
      LF_AND:  res_o = b_i & a_i;
      LF_XOR:  res_o = b_i ^ a_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu import flag_alu_pkg::*; #(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             upd_i,
  output logic [W-1:0]     res_o,
  output logic [NFLG-1:0]  flags_next_o,
  output logic [NFLG-1:0]  flags_o
);
  logic [W-1:0]    ar_x, ar_y, ar_sum, lg_a, lg_res;
  logic            ar_sub, ar_cy, ar_ov, zero;
  logic_fn_e       lg_fn;
  op_cls_e         cls;
  logic [NFLG-1:0] flags_q;

  alu_opsel #(.W(W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) u_sel (
    .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .ar_x_o(ar_x), .ar_y_o(ar_y), .ar_sub_o(ar_sub),
    .lg_a_o(lg_a), .lg_fn_o(lg_fn), .cls_o(cls)
  );

  alu_arith #(.W(W)) u_arith (
    .x_i(ar_x), .y_i(ar_y), .sub_i(ar_sub),
    .sum_o(ar_sum), .cy_o(ar_cy), .ov_o(ar_ov)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(lg_a), .b_i(opb_i), .fn_i(lg_fn), .res_o(lg_res)
  );

  always_comb begin
    flags_next_o = flags_q;
    case (cls)
      CLS_ARITH: res_o = ar_sum;
      CLS_LOGIC,
      CLS_ANDI:  res_o = lg_res;
      default:   res_o = '0;
    endcase
    zero = (res_o == '0);
    case (cls)
      CLS_ARITH: begin
        flags_next_o[FLG_Z]  = zero;
        flags_next_o[FLG_S]  = res_o[W-1];
        flags_next_o[FLG_OV] = ar_ov;
        flags_next_o[FLG_CY] = ar_cy;
      end
      CLS_LOGIC: begin
        flags_next_o[FLG_Z]  = zero;
        flags_next_o[FLG_S]  = res_o[W-1];
        flags_next_o[FLG_OV] = 1'b0;
      end
      CLS_ANDI: begin
        flags_next_o[FLG_Z]  = zero;
        flags_next_o[FLG_S]  = 1'b0;
        flags_next_o[FLG_OV] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q <= flags_next_o;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk import flag_alu_pkg::*; #(
  parameter int W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      op_i,
  input logic            upd_i,
  input logic [W-1:0]    res_o,
  input logic [NFLG-1:0] flags_next_o,
  input logic [NFLG-1:0] flags_o
);
  logic is_lg, is_ar, is_rsv;
  assign is_lg  = (op_i >= 4'(OP_OR)) && (op_i <= 4'(OP_NOT)) && (op_i != 4'(OP_ANDI));
  assign is_ar  = (op_i <= 4'(OP_RSUB));
  assign is_rsv = (op_i > 4'(OP_NOT));

  AST_FLAGS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o == $past(flags_next_o)); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o)); // R8
  AST_ARITH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ar |-> flags_next_o[FLG_Z] == (res_o == '0)); // R3
  AST_LOGIC_KEEP_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lg |-> !flags_next_o[FLG_OV] && flags_next_o[FLG_CY] == flags_o[FLG_CY]); // R6
  AST_ANDI_Z_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'(OP_ANDI) |-> !flags_next_o[FLG_S] && !flags_next_o[FLG_OV]
                            && flags_next_o[FLG_CY] == flags_o[FLG_CY]); // R7
  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rsv |-> res_o == '0 && flags_next_o == flags_o); // R9
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .upd_i(upd_i),
  .res_o(res_o), .flags_next_o(flags_next_o), .flags_o(flags_o)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [15:0] imm_i = '0;
  logic        upd_i = 1'b0;
  logic [31:0] res_o;
  logic [3:0]  flags_next_o, flags_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] mflags = '0;

  always #4 clk_i = ~clk_i;

  flag_alu u0 (.*);

  function automatic string res_tag(int op);
    if (op <= 2) return "R2";
    if (op == 3) return "R4";
    if (op == 4) return "R5";
    if (op == 8) return "R7";
    if (op <= 11) return "R6";
    return "R9";
  endfunction

  function automatic string flg_tag(int op);
    if (op <= 2) return "R3";
    return res_tag(op);
  endfunction

  // returns {flags[3:0], result[31:0]}; flags: bit0 Z, 1 S, 2 OV, 3 CY
  function automatic logic [35:0] model(int op, logic [31:0] r1, logic [31:0] r2,
                                        logic [15:0] im, logic [3:0] f);
    logic [31:0] y, r, zx;
    longint sx, sy, sr;
    logic z, s, ov, cy;
    zx = {16'h0, im};
    cy = f[3]; ov = f[2]; s = f[1]; z = f[0];
    r = '0;
    case (op)
      0, 1, 2: begin
        y  = (op == 0) ? r1 : (op == 1) ? {{27{im[4]}}, im[4:0]} : {{16{im[15]}}, im};
        r  = r2 + y;
        cy = ((longint'(r2) + longint'(y)) >= 64'sh1_0000_0000);
        sr = longint'($signed(r2)) + longint'($signed(y));
        ov = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000);
      end
      3, 4: begin
        sx = (op == 3) ? longint'($signed(r2)) : longint'($signed(r1));
        sy = (op == 3) ? longint'($signed(r1)) : longint'($signed(r2));
        r  = (op == 3) ? r2 - r1 : r1 - r2;
        cy = (op == 3) ? (r2 < r1) : (r1 < r2);
        sr = sx - sy;
        ov = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000);
      end
      5:  r = r2 | r1;
      6:  r = r2 | zx;
      7:  r = r2 & r1;
      8:  r = r2 & zx;
      9:  r = r2 ^ r1;
      10: r = r2 ^ zx;
      11: r = ~r1;
      default: r = '0;
    endcase
    if (op <= 11) begin
      z = (r == 0);
      s = (op == 8) ? 1'b0 : r[31];
      if (op >= 5) ov = 1'b0;
    end
    return {cy, ov, s, z, r};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int op, logic [31:0] r1, logic [31:0] r2, logic [15:0] im, bit upd);
    logic [35:0] e;
    @(negedge clk_i);
    op_i = 4'(op); opa_i = r1; opb_i = r2; imm_i = im; upd_i = upd;
    #1;
    e = model(op, r1, r2, im, mflags);
    check(res_tag(op), "result", res_o, e[31:0]);
    check(flg_tag(op), "next flags", {28'h0, flags_next_o}, {28'h0, e[35:32]});
    @(posedge clk_i);
    if (upd) mflags = e[35:32];
    #1;
    check("R8", "committed flags", {28'h0, flags_o}, {28'h0, mflags});
  endtask

  initial begin
    logic [31:0] corner [4];
    logic [15:0] icorn [5];
    corner = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    icorn  = '{16'h0000, 16'h000F, 16'h0010, 16'h7FFF, 16'h8000};
    void'($urandom(32'd2024));
    #3;
    check("R1", "flags in reset", {28'h0, flags_o}, 32'h0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "flags after reset", {28'h0, flags_o}, 32'h0);
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply(op, corner[i], corner[j], icorn[(i + j + op) % 5], 1'b1);
    // carry kept across logic ops, and strobe-low hold
    apply(0, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b1);
    apply(5, 32'h0, 32'h0, 16'h0, 1'b1);
    apply(8, 32'h0, 32'hFFFF_FFFF, 16'h8000, 1'b1);
    apply(3, 32'h5, 32'h3, 16'h0, 1'b0);
    apply(4, 32'h5, 32'h3, 16'h0, 1'b1);
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if ((k % 7) == 0) a = corner[k % 4];
      if ((k % 11) == 0) b = -a;
      apply(int'($urandom_range(0, 13)), a, b, 16'($urandom()), bit'($urandom_range(0, 1)));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule